// File: doc/BRIEF.md
# Cartridge Bank Mapper with Masked Outer/Inner Banking

This block sits on the CPU bus of an 8-bit console cartridge and turns a set of control registers into bank numbers for the program and picture memories. The CPU writes to three groups of addresses. A sixteen-entry expansion register file is at 0x4100 through 0x410F. Two picture-side registers are at 0x2018 and 0x201A. A select/data register pair sits in the 0x8000 to 0xFFFF range. From these registers the block produces four 8 KB program bank numbers, eight 1 KB character bank numbers and a nametable mirroring bit.

Each bank number joins an outer base to inner bank bits. A shift field sets the mask that divides the two parts. This lets one large memory hold many smaller images, each of which sees an ordinary banking scheme. The outputs are combinational from the registers. A write captured at one clock edge therefore shows on the bank outputs in the cycle that follows. Program storage, the scanline interrupt counter and audio playback belong to other blocks.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous reset, every control register is 0 except register 9 (0x3E) and register 10 (0x3F). The outputs are then: program windows 0x000, 0x000, 0x03E and 0x03F; character windows 0,1,0,1,0,0,0,0; mirroring bit 0.
- R2: A write to 0x4100+N stores the data byte in register N, for N from 0 to 15. A write to 0x2018 loads register 12. A write to 0x201A loads register 13. Register 14 bit 0 is the mirroring output.
- R3: Addresses from 0x8000 up are decoded on (address AND 0xE001). Class 0x8000 stores the data in the select register (register 15). Class 0xA000 sets register 14 to the inverse of data bit 0. Class 0x8001 writes the data for command select[2:0].
- R4: Commands 0 to 5 store (data AND m) into character register 0 to 5. Here m is 0x0F when register 13 bit 2 is set, and 0xFF shifted right by register 11 bits [7:4] otherwise.
- R5: Commands 6 and 7 replace only the bits under the program mask p in register 7 or register 8. The mask p is 0x3F shifted right by register 11 bits [3:0]. All other bits of the target keep their value.
- R6: A masked program bank equals (register 0 bits [7:4] at bank bits [11:8]) OR (inner AND p) OR (register 10 AND NOT p).
- R7: When register 13 bit 1 is set, windows 0, 1 and 2 take the masked banks from registers 7, 8 and 9, and window 3 takes the base OR register 10 unmasked. When bit 1 is clear, windows 2 and 3 take the masked inner values 0xFE and 0xFF.
- R8: Program windows 0 and 2 exchange their banks only when register 13 bit 0 and select bit 6 are both set.
- R9: When select bit 7 is set, character windows 0 to 3 exchange with windows 4 to 7.
- R10: The character base is ((reg0[3:0]<<8) | (reg12<<1) | reg13[7:3]) << 3, ORed into every inner bank. Character register 0 maps slots 0 and 1 with bit 0 forced to 0 and then to 1. Register 1 does the same for slots 2 and 3. Registers 2 to 5 map slots 4 to 7.
- R11: A register write is visible on all outputs in the cycle after its clock edge. Without a write the outputs hold. Writes to other addresses, such as 0x4110, 0x2019 and the 0xA001, 0xC000 and 0xE001 classes, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per bus write |
| prg_bank | output | 4x12 | 8 KB program bank for windows 0x8000, 0xA000, 0xC000, 0xE000 |
| chr_bank | output | 8x15 | 1 KB character bank for each picture window |
| mirror | output | 1 | Nametable mirroring select |

## Verification
The assertions assume that each bus write is a single-cycle strobe with stable address and data in that cycle. They also assume that reset is held for at least one clock before any write. The bench drives every write in its own cycle from the falling edge, with a cycle of separation. It keeps reset asserted across several edges before its first access. Because of this, each write maps to exactly one capture edge and one expected output state.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    localparam int NREG     = 16;
    localparam int NCHRREG  = 6;
    localparam int PRG_WIN  = 4;
    localparam int CHR_WIN  = 8;
    localparam int BYTE_W   = 8;
    localparam int OUTER_W  = 4;
    localparam int PRG_W    = OUTER_W + BYTE_W;
    localparam int CHR_HI_W = OUTER_W + BYTE_W;
    localparam int CHR_SUB  = 3;
    localparam int CHR_W    = CHR_HI_W + CHR_SUB;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int HALF_CHR = CHR_WIN / 2;

    // register roles (index in the control file)
    localparam logic [RIDX_W-1:0] IX_OUTER = 4'h0;
    localparam logic [RIDX_W-1:0] IX_PB0   = 4'h7;
    localparam logic [RIDX_W-1:0] IX_PB1   = 4'h8;
    localparam logic [RIDX_W-1:0] IX_PB2   = 4'h9;
    localparam logic [RIDX_W-1:0] IX_PFILL = 4'hA;
    localparam logic [RIDX_W-1:0] IX_SHIFT = 4'hB;
    localparam logic [RIDX_W-1:0] IX_CHI   = 4'hC;
    localparam logic [RIDX_W-1:0] IX_MODE  = 4'hD;
    localparam logic [RIDX_W-1:0] IX_MIRR  = 4'hE;
    localparam logic [RIDX_W-1:0] IX_SEL   = 4'hF;

    localparam logic [BYTE_W-1:0] RST_PB2   = 8'h3E;
    localparam logic [BYTE_W-1:0] RST_PFILL = 8'h3F;
    localparam logic [BYTE_W-1:0] PRG_FULL  = 8'h3F;
    localparam logic [BYTE_W-1:0] CHR_NARROW = 8'h0F;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t [NREG-1:0]    r;
        byte_t [NCHRREG-1:0] c;
    } map_state_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_EXP, OP_CHI, OP_MODE, OP_SEL, OP_DATA, OP_MIRR
    } bus_op_e;

    function automatic byte_t prg_mask(input byte_t shift_reg);
        return PRG_FULL >> shift_reg[3:0];
    endfunction

    function automatic byte_t chr_mask(input byte_t mode_reg, input byte_t shift_reg);
        return mode_reg[2] ? CHR_NARROW : (8'hFF >> shift_reg[7:4]);
    endfunction

    function automatic logic [PRG_W-1:0] prg_join(input byte_t outer, input byte_t inner,
                                                  input byte_t fill, input byte_t m);
        byte_t low;
        low = (inner & m) | (fill & ~m);
        return {outer[7:4], BYTE_W'(0)} | {{OUTER_W{1'b0}}, low};
    endfunction

endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
    import bank_mapper_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_we,
    output bus_op_e     op
);
    logic [15:0] mmc_class;

    always_comb begin
        mmc_class = cpu_addr & 16'hE001;
        op = OP_NONE;
        if (cpu_we) begin
            if (cpu_addr[15:4] == 12'h410)       op = OP_EXP;
            else if (cpu_addr == 16'h2018)       op = OP_CHI;
            else if (cpu_addr == 16'h201A)       op = OP_MODE;
            else if (cpu_addr[15]) begin
                unique case (mmc_class)
                    16'h8000: op = OP_SEL;
                    16'h8001: op = OP_DATA;
                    16'hA000: op = OP_MIRR;
                    default:  op = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
    import bank_mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  bus_op_e     op,
    output map_state_t  st
);
    logic [2:0]  cmd;
    byte_t       cmask;
    byte_t       pmask;
    logic [RIDX_W-1:0] ptgt;

    always_comb begin
        cmd   = st.r[IX_SEL][2:0];
        cmask = chr_mask(st.r[IX_MODE], st.r[IX_SHIFT]);
        pmask = prg_mask(st.r[IX_SHIFT]);
        ptgt  = cmd[0] ? IX_PB1 : IX_PB0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) st.r[i] <= '0;
            for (int j = 0; j < NCHRREG; j++) st.c[j] <= '0;
            st.r[IX_PB2]   <= RST_PB2;
            st.r[IX_PFILL] <= RST_PFILL;
        end else begin
            unique case (op)
                OP_EXP:  st.r[cpu_addr[3:0]] <= cpu_data;
                OP_CHI:  st.r[IX_CHI]        <= cpu_data;
                OP_MODE: st.r[IX_MODE]       <= cpu_data;
                OP_SEL:  st.r[IX_SEL]        <= cpu_data;
                OP_MIRR: st.r[IX_MIRR]       <= {7'b0, ~cpu_data[0]};
                OP_DATA: begin
                    if (cmd < 3'd6)
                        st.c[cmd] <= cpu_data & cmask;
                    else
                        st.r[ptgt] <= (st.r[ptgt] & ~pmask) | (cpu_data & pmask);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mapper_prg.sv
module mapper_prg
    import bank_mapper_pkg::*;
(
    input  map_state_t                   st,
    output logic [PRG_WIN-1:0][PRG_W-1:0] prg_bank
);
    byte_t m;
    logic  four_reg;
    logic  swap;
    logic [PRG_WIN-1:0][PRG_W-1:0] slot;

    always_comb begin
        m        = prg_mask(st.r[IX_SHIFT]);
        four_reg = st.r[IX_MODE][1];
        swap     = st.r[IX_MODE][0] & st.r[IX_SEL][6];
        slot[0]  = prg_join(st.r[IX_OUTER], st.r[IX_PB0], st.r[IX_PFILL], m);
        slot[1]  = prg_join(st.r[IX_OUTER], st.r[IX_PB1], st.r[IX_PFILL], m);
        if (four_reg) begin
            slot[2] = prg_join(st.r[IX_OUTER], st.r[IX_PB2], st.r[IX_PFILL], m);
            slot[3] = prg_join(st.r[IX_OUTER], st.r[IX_PFILL], st.r[IX_PFILL], 8'hFF);
        end else begin
            slot[2] = prg_join(st.r[IX_OUTER], 8'hFE, st.r[IX_PFILL], m);
            slot[3] = prg_join(st.r[IX_OUTER], 8'hFF, st.r[IX_PFILL], m);
        end
    end

    // window w takes slot w, except 0 and 2 trade places when swapped
    for (genvar w = 0; w < PRG_WIN; w++) begin : g_win
        if (w == 0 || w == 2) begin : g_swp
            assign prg_bank[w] = swap ? slot[w ^ 2] : slot[w];
        end else begin : g_fix
            assign prg_bank[w] = slot[w];
        end
    end
endmodule

// File: rtl/mapper_chr.sv
module mapper_chr
    import bank_mapper_pkg::*;
(
    input  map_state_t                   st,
    output logic [CHR_WIN-1:0][CHR_W-1:0] chr_bank
);
    logic [CHR_HI_W-1:0] hi;
    logic [CHR_W-1:0]    base;
    logic                half_swap;
    logic [CHR_WIN-1:0][CHR_W-1:0] slot;

    always_comb begin
        hi = {st.r[IX_OUTER][3:0], BYTE_W'(0)}
           | {3'b000, st.r[IX_CHI], 1'b0}
           | {7'b0, st.r[IX_MODE][7:3]};
        base      = {hi, {CHR_SUB{1'b0}}};
        half_swap = st.r[IX_SEL][7];
    end

    for (genvar s = 0; s < CHR_WIN; s++) begin : g_slot
        if (s < HALF_CHR) begin : g_pair
            assign slot[s] = base | {{(CHR_W-BYTE_W){1'b0}},
                                     st.c[s/2][7:1], 1'(s % 2)};
        end else begin : g_single
            assign slot[s] = base | {{(CHR_W-BYTE_W){1'b0}}, st.c[s - HALF_CHR + 2]};
        end
        assign chr_bank[s] = half_swap ? slot[s ^ HALF_CHR] : slot[s];
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [15:0]                   cpu_addr,
    input  logic [7:0]                    cpu_data,
    input  logic                          cpu_we,
    output logic [PRG_WIN-1:0][PRG_W-1:0] prg_bank,
    output logic [CHR_WIN-1:0][CHR_W-1:0] chr_bank,
    output logic                          mirror
);
    bus_op_e    op;
    map_state_t st;

    mapper_decode u_dec (.cpu_addr(cpu_addr), .cpu_we(cpu_we), .op(op));

    mapper_regs u_regs (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .op(op), .st(st)
    );

    mapper_prg u_prg (.st(st), .prg_bank(prg_bank));
    mapper_chr u_chr (.st(st), .chr_bank(chr_bank));

    assign mirror = st.r[IX_MIRR][0];
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bank_mapper_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [15:0]                   cpu_addr,
    input logic [7:0]                    cpu_data,
    input logic                          cpu_we,
    input logic [PRG_WIN-1:0][PRG_W-1:0] prg_bank,
    input logic [CHR_WIN-1:0][CHR_W-1:0] chr_bank,
    input logic                          mirror,
    input map_state_t                    st
);
    byte_t pm;
    assign pm = prg_mask(st.r[IX_SHIFT]);

    p_exp_store_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_we && cpu_addr == 16'h4109 |=> st.r[IX_PB2] == $past(cpu_data));

    p_mirror_inv_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_we && ((cpu_addr & 16'hE001) == 16'hA000) |=> mirror == !$past(cpu_data[0]));

    p_last_fixed_r7: assert property (@(posedge clk) disable iff (rst)
        !st.r[IX_MODE][1] |-> ((prg_bank[3][7:0] & pm) == pm));

    p_pair_parity_r10: assert property (@(posedge clk) disable iff (rst)
        !st.r[IX_SEL][7] |-> (chr_bank[1][0] && !chr_bank[0][0]));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !cpu_we |=> $stable(prg_bank) && $stable(chr_bank) && $stable(mirror));
endmodule

bind bank_mapper bank_mapper_chk u_chk (.*);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
    import bank_mapper_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [PRG_WIN-1:0][PRG_W-1:0] p;
        logic [CHR_WIN-1:0][CHR_W-1:0] c;
        logic                          m;
    } exp_t;

    logic clk = 0, rst = 1, cpu_we = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [PRG_WIN-1:0][PRG_W-1:0] prg_bank;
    logic [CHR_WIN-1:0][CHR_W-1:0] chr_bank;
    logic mirror;

    int checks = 0, errors = 0;
    exp_t  q_exp[$];
    string q_tag[$];
    event  ev_chk;
    byte_t mr[NREG];
    byte_t mc[NCHRREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mapper uut (.clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
                     .cpu_we(cpu_we), .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror));

    function automatic logic [11:0] pj(byte_t inner, byte_t m, byte_t outer, byte_t fill);
        return {outer[7:4], 8'h00} | {4'h0, (inner & m) | (fill & ~m)};
    endfunction

    function automatic exp_t predict();
        exp_t e;
        byte_t m;
        logic [11:0] s[4];
        logic [14:0] cb, cs[8];
        m = 8'h3F >> mr[11][3:0];
        s[0] = pj(mr[7], m, mr[0], mr[10]);
        s[1] = pj(mr[8], m, mr[0], mr[10]);
        if (mr[13][1]) begin
            s[2] = pj(mr[9], m, mr[0], mr[10]);
            s[3] = {mr[0][7:4], mr[10]};
        end else begin
            s[2] = pj(8'hFE, m, mr[0], mr[10]);
            s[3] = pj(8'hFF, m, mr[0], mr[10]);
        end
        if (mr[13][0] && mr[15][6]) begin
            logic [11:0] t;
            t = s[0]; s[0] = s[2]; s[2] = t;
        end
        for (int i = 0; i < 4; i++) e.p[i] = s[i];
        cb = 15'({4'(mr[0][3:0]), 8'h00} | {3'b0, mr[12], 1'b0} | {7'b0, mr[13][7:3]}) << 3;
        cs[0] = cb | {7'b0, mc[0] & 8'hFE};
        cs[1] = cb | {7'b0, mc[0] | 8'h01};
        cs[2] = cb | {7'b0, mc[1] & 8'hFE};
        cs[3] = cb | {7'b0, mc[1] | 8'h01};
        for (int i = 2; i < 6; i++) cs[i+2] = cb | {7'b0, mc[i]};
        for (int i = 0; i < 8; i++) e.c[i] = mr[15][7] ? cs[i ^ 4] : cs[i];
        e.m = mr[14][0];
        return e;
    endfunction

    task automatic model_write(logic [15:0] a, byte_t d);
        if (a[15:4] == 12'h410) mr[a[3:0]] = d;
        else if (a == 16'h2018) mr[12] = d;
        else if (a == 16'h201A) mr[13] = d;
        else if (a[15]) begin
            case (a & 16'hE001)
                16'h8000: mr[15] = d;
                16'hA000: mr[14] = {7'b0, ~d[0]};
                16'h8001: begin
                    int cmd;
                    byte_t m;
                    cmd = int'(mr[15][2:0]);
                    if (cmd < 6) begin
                        m = mr[13][2] ? 8'h0F : (8'hFF >> mr[11][7:4]);
                        mc[cmd] = d & m;
                    end else begin
                        m = 8'h3F >> mr[11][3:0];
                        mr[cmd+1] = (mr[cmd+1] & ~m) | (d & m);
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic expect_now(string tag);
        q_exp.push_back(predict());
        q_tag.push_back(tag);
        -> ev_chk;
    endtask

    task automatic wr(logic [15:0] a, byte_t d, string tag);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = 1;
        @(negedge clk);
        cpu_we = 0;
        model_write(a, d);
        expect_now(tag);
    endtask

    task automatic idle(int n, string tag);
        repeat (n) @(negedge clk);
        expect_now(tag);
    endtask

    // monitor: pops one expected item per event, compares every window
    initial begin
        forever begin
            @(ev_chk);
            while (q_exp.size() > 0) begin
                exp_t e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                for (int i = 0; i < PRG_WIN; i++) begin
                    checks++;
                    if (prg_bank[i] !== e.p[i]) begin
                        errors++;
                        $display("FAIL %s prg window %0d: actual %03h expected %03h", t, i, prg_bank[i], e.p[i]);
                    end
                end
                for (int i = 0; i < CHR_WIN; i++) begin
                    checks++;
                    if (chr_bank[i] !== e.c[i]) begin
                        errors++;
                        $display("FAIL %s chr window %0d: actual %04h expected %04h", t, i, chr_bank[i], e.c[i]);
                    end
                end
                checks++;
                if (mirror !== e.m) begin
                    errors++;
                    $display("FAIL %s mirror: actual %0b expected %0b", t, mirror, e.m);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) mr[i] = 8'h00;
        for (int i = 0; i < NCHRREG; i++) mc[i] = 8'h00;
        mr[9] = 8'h3E; mr[10] = 8'h3F;
        repeat (3) @(negedge clk);
        rst = 0;
        idle(1, "R1 reset");
        // outer bases and picture registers
        wr(16'h4100, 8'h52, "R2 R6 R10 outer");
        wr(16'h2018, 8'h81, "R2 R10 chr hi");
        wr(16'h201A, 8'h28, "R2 R10 mode low");
        // character commands under masks
        wr(16'h8000, 8'h00, "R3 sel0");
        wr(16'h8001, 8'h37, "R4 R10 chr0 full");
        wr(16'h410B, 8'h20, "R2 shift");
        wr(16'h8000, 8'h01, "R3 sel1");
        wr(16'h8001, 8'hFF, "R4 chr1 shifted mask");
        wr(16'h201A, 8'h2C, "R4 narrow on");
        wr(16'h8000, 8'h02, "R3 sel2");
        wr(16'h8001, 8'hAB, "R4 chr2 narrow");
        wr(16'h8000, 8'h03, "R3 sel3");
        wr(16'h9FFF, 8'h5C, "R3 R4 alias data");
        wr(16'h8000, 8'h04, "R3 sel4");
        wr(16'h8001, 8'h66, "R4 chr4");
        wr(16'h8000, 8'h05, "R3 sel5");
        wr(16'h8001, 8'h09, "R4 chr5");
        // program commands merge under mask
        wr(16'h8000, 8'h06, "R3 sel6");
        wr(16'h8001, 8'h15, "R5 pb0");
        wr(16'h410B, 8'h22, "R5 prg shift 2");
        wr(16'h8000, 8'h07, "R3 sel7");
        wr(16'h8001, 8'hFF, "R5 pb1 low");
        wr(16'h4108, 8'hA0, "R2 pb1 direct");
        wr(16'h8001, 8'h03, "R5 pb1 merge");
        wr(16'h410A, 8'h7C, "R6 fill");
        // mode and swaps
        wr(16'h201A, 8'h2E, "R7 four reg");
        wr(16'h4109, 8'h11, "R7 pb2");
        wr(16'h8000, 8'h46, "R8 no swap gate clear");
        wr(16'h201A, 8'h2F, "R8 swap gated on");
        wr(16'h201A, 8'h2D, "R7 R8 fixed mode swapped");
        wr(16'h8000, 8'hC0, "R9 chr halves");
        wr(16'h8000, 8'h00, "R9 chr halves back");
        // mirroring
        wr(16'hA000, 8'h01, "R3 mirror0");
        wr(16'hA000, 8'h00, "R3 mirror1");
        wr(16'hBFFE, 8'h01, "R3 mirror alias");
        wr(16'h410E, 8'h01, "R2 mirror direct");
        // ignored addresses
        wr(16'hA001, 8'hFF, "R11 ignore a001");
        wr(16'hC000, 8'hFF, "R11 ignore c000");
        wr(16'hE001, 8'hFF, "R11 ignore e001");
        wr(16'h4110, 8'hFF, "R11 ignore 4110");
        wr(16'h2019, 8'hFF, "R11 ignore 2019");
        idle(5, "R11 hold");
        // reset again returns defaults
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < NREG; i++) mr[i] = 8'h00;
        for (int i = 0; i < NCHRREG; i++) mc[i] = 8'h00;
        mr[9] = 8'h3E; mr[10] = 8'h3F;
        expect_now("R1 second reset");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule